// File: doc/BRIEF.md
# Instruction Sequencer with Interrupt Entry and Trap Dispatch

This block is the control sequencer of a small stored-program processor. It owns the program counter, the instruction register, a halt flag, an interrupt-enable flag and a privilege mode bit. It steps through fetch, execute and advance on a single-port, word-addressed memory whose read data arrives one cycle after the read strobe. Decoding is kept outside: a few decode inputs, derived from the instruction register by the surrounding logic, tell the sequencer whether the current word is a halt, a trap with its number, an interrupt-enable or a return from interrupt. The ALU and the register file are not part of this block.

After each ordinary instruction the sequencer advances the program counter and then looks at the external interrupt request. If the request is high and interrupts are enabled, it disables interrupts, stores the advanced program counter in memory word 0 and jumps to the address held in memory word 1. A trap with number n in the range 1 to TRAP_CNT switches to supervisor mode and jumps to the address held at word TRAP_BASE+n, with no interrupt check in between. A return reloads the program counter from word 0, enables interrupts and goes back to user mode.

States: ST_FETCH (read strobe at PC) goes to ST_FWAIT (IR captured), then to ST_EXEC. From ST_EXEC: halt goes to ST_HALT (terminal); a valid trap goes to ST_TRD (table read, supervisor set) then ST_TLD (PC loaded) then ST_FETCH; an invalid trap goes back to ST_FETCH; return goes to ST_RRD (word 0 read) then ST_RLD (PC loaded) then ST_FETCH; anything else goes to ST_ICHK. ST_ICHK goes to ST_ISAVE (PC written to word 0) when a request is taken, otherwise to ST_FETCH. ST_ISAVE goes to ST_IVRD (word 1 read), then ST_IVLD (PC loaded), then ST_FETCH.

Top module: `instr_seq`

## Requirements
- R1: While reset is held, PC equals START_PC (16), and the halt flag, interrupt enable, supervisor mode and trap error flag are all 0.
- R2: Each fetch issues one read at the PC and captures the read data one cycle later into the IR; an ordinary instruction (opcode field IR[15:12] = 0 in the bench encoding) advances the PC by exactly one.
- R3: A halt instruction (opcode 1) sets the halt flag and advances the PC by one; after that the flag stays set and no read or write strobe is issued until reset.
- R4: An interrupt request is acted on only in the cycle after an instruction has finished and the PC has advanced, and only while interrupt enable is 1; with enable at 0 a held request causes no write and no change of flow.
- R5: Taking an interrupt clears interrupt enable before the save write, writes the advanced PC to word 0, then reads word 1 and loads the PC with its contents; the mode bit is left as it was.
- R6: A trap (opcode 2, number in IR[2:0]) with number n from 1 to TRAP_CNT (4) sets supervisor mode and loads the PC from word TRAP_BASE+n (1000+n), going straight to the next fetch with no interrupt check.
- R7: A trap number outside 1..TRAP_CNT sets the sticky trap error flag, leaves PC and mode unchanged and starts the next fetch at the same PC.
- R8: A return (opcode 4) loads the PC from word 0, sets interrupt enable and selects user mode.
- R9: An interrupt-enable instruction (opcode 3) sets interrupt enable and advances the PC by one.
- R10: Timing is fixed: an ordinary instruction takes 4 cycles, a halt 3, interrupt entry 3 cycles after the check, a valid trap 5, a return 5; read and write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | External interrupt request, level sensitive |
| dec_halt | input | 1 | Current IR is a halt |
| dec_trap | input | 1 | Current IR is a trap |
| dec_trap_num | input | TW | Trap number of the current IR |
| dec_ien | input | 1 | Current IR enables interrupts |
| dec_ret | input | 1 | Current IR returns from interrupt |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Read strobe, data valid next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| pc_o | output | AW | Program counter |
| ir_o | output | DW | Instruction register |
| halted_o | output | 1 | Halt flag |
| ien_o | output | 1 | Interrupt enable flag |
| super_o | output | 1 | Supervisor mode |
| trap_err_o | output | 1 | Sticky invalid-trap flag |

## Verification
The hardest situation to reach is the round trip where an interrupt is taken right after the instruction that enabled interrupts, and the handler then returns with the request no longer pending, so that return restores both the saved PC and the enable without an immediate second entry. The bench holds the request high from reset, places the enable instruction at a swept offset behind a run of no-ops, and lowers the request as soon as it sees the save write strobe, so the return lands on a halt at the saved address. Cycle counts to the halt are predicted from the per-instruction timings and compared for each path.

// File: rtl/instr_seq_pkg.sv
package instr_seq_pkg;
    typedef enum logic [3:0] {
        ST_FETCH,
        ST_FWAIT,
        ST_EXEC,
        ST_ICHK,
        ST_ISAVE,
        ST_IVRD,
        ST_IVLD,
        ST_TRD,
        ST_TLD,
        ST_RRD,
        ST_RLD,
        ST_HALT
    } seq_state_e;
endpackage

// File: rtl/trap_vec_calc.sv
module trap_vec_calc #(
    parameter int AW        = 11,
    parameter int TW        = 3,
    parameter int TRAP_CNT  = 4,
    parameter int TRAP_BASE = 1000
) (
    input  logic [TW-1:0] num,
    output logic [AW-1:0] vec_addr,
    output logic          num_ok
);
    localparam logic [AW-1:0] BASE_W = AW'(TRAP_BASE);

    assign vec_addr = BASE_W + AW'(num);
    assign num_ok   = (int'(num) >= 1) && (int'(num) <= TRAP_CNT);
endmodule

// File: rtl/instr_seq.sv
module instr_seq
    import instr_seq_pkg::*;
#(
    parameter int AW        = 11,
    parameter int DW        = 16,
    parameter int TW        = 3,
    parameter int TRAP_CNT  = 4,
    parameter int TRAP_BASE = 1000,
    parameter int START_PC  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_req,
    input  logic          dec_halt,
    input  logic          dec_trap,
    input  logic [TW-1:0] dec_trap_num,
    input  logic          dec_ien,
    input  logic          dec_ret,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] ir_o,
    output logic          halted_o,
    output logic          ien_o,
    output logic          super_o,
    output logic          trap_err_o
);
    localparam logic [AW-1:0] SAVE_ADDR = '0;
    localparam logic [AW-1:0] VEC_ADDR  = AW'(1);
    localparam logic [AW-1:0] RST_PC    = AW'(START_PC);

    seq_state_e state_q, state_d;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] ir_q;
    logic halted_q, ien_q, super_q, err_q;
    logic [AW-1:0] tvec;
    logic tnum_ok;
    logic irq_take;

    trap_vec_calc #(
        .AW(AW), .TW(TW), .TRAP_CNT(TRAP_CNT), .TRAP_BASE(TRAP_BASE)
    ) u_vec (
        .num(dec_trap_num),
        .vec_addr(tvec),
        .num_ok(tnum_ok)
    );

    assign irq_take = irq_req && ien_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_FWAIT;
            ST_FWAIT: state_d = ST_EXEC;
            ST_EXEC: begin
                if (dec_halt)      state_d = ST_HALT;
                else if (dec_trap) state_d = tnum_ok ? ST_TRD : ST_FETCH;
                else if (dec_ret)  state_d = ST_RRD;
                else               state_d = ST_ICHK;
            end
            ST_ICHK:  state_d = irq_take ? ST_ISAVE : ST_FETCH;
            ST_ISAVE: state_d = ST_IVRD;
            ST_IVRD:  state_d = ST_IVLD;
            ST_IVLD:  state_d = ST_FETCH;
            ST_TRD:   state_d = ST_TLD;
            ST_TLD:   state_d = ST_FETCH;
            ST_RRD:   state_d = ST_RLD;
            ST_RLD:   state_d = ST_FETCH;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_FETCH;
        endcase
    end

    // architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= RST_PC;
            ir_q     <= '0;
            halted_q <= 1'b0;
            ien_q    <= 1'b0;
            super_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FWAIT: ir_q <= mem_rdata;
                ST_EXEC: begin
                    if (dec_halt) begin
                        halted_q <= 1'b1;
                        pc_q     <= pc_q + AW'(1);
                    end else if (dec_trap) begin
                        if (!tnum_ok) err_q <= 1'b1;
                    end else if (!dec_ret) begin
                        pc_q <= pc_q + AW'(1);
                        if (dec_ien) ien_q <= 1'b1;
                    end
                end
                ST_ICHK: if (irq_take) ien_q <= 1'b0;
                ST_TRD:  super_q <= 1'b1;
                ST_TLD:  pc_q <= mem_rdata[AW-1:0];
                ST_IVLD: pc_q <= mem_rdata[AW-1:0];
                ST_RLD: begin
                    pc_q    <= mem_rdata[AW-1:0];
                    ien_q   <= 1'b1;
                    super_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // memory strobes
    always_comb begin
        mem_addr  = pc_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = {{(DW-AW){1'b0}}, pc_q};
        unique case (state_q)
            ST_FETCH: mem_rd = 1'b1;
            ST_ISAVE: begin
                mem_wr   = 1'b1;
                mem_addr = SAVE_ADDR;
            end
            ST_IVRD: begin
                mem_rd   = 1'b1;
                mem_addr = VEC_ADDR;
            end
            ST_TRD: begin
                mem_rd   = 1'b1;
                mem_addr = tvec;
            end
            ST_RRD: begin
                mem_rd   = 1'b1;
                mem_addr = SAVE_ADDR;
            end
            default: ;
        endcase
    end

    assign pc_o       = pc_q;
    assign ir_o       = ir_q;
    assign halted_o   = halted_q;
    assign ien_o      = ien_q;
    assign super_o    = super_q;
    assign trap_err_o = err_q;
endmodule

// File: rtl/instr_seq_chk.sv
module instr_seq_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          halted_o,
    input logic          ien_o,
    input logic          trap_err_o
);
    p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_halt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> (!mem_rd && !mem_wr));

    p_halt_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o);

    p_save_word0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == '0 && !ien_o));

    p_vec_after_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (mem_rd && mem_addr == AW'(1)));

    p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(ien_o));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_err_o |=> trap_err_o);
endmodule

bind instr_seq instr_seq_chk #(.AW(AW)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .mem_addr(mem_addr),
    .mem_rd(mem_rd),
    .mem_wr(mem_wr),
    .halted_o(halted_o),
    .ien_o(ien_o),
    .trap_err_o(trap_err_o)
);

// File: tb/instr_seq_tb_top.sv
module instr_seq_tb_top;
    localparam int AW = 11;
    localparam int DW = 16;
    localparam int TW = 3;
    localparam int NT = 4;
    localparam int TB = 1000;
    localparam int SP = 16;
    localparam logic [DW-1:0] OP_NOP  = 16'h0000;
    localparam logic [DW-1:0] OP_HALT = 16'h1000;
    localparam logic [DW-1:0] OP_TRAP = 16'h2000;
    localparam logic [DW-1:0] OP_IEN  = 16'h3000;
    localparam logic [DW-1:0] OP_RET  = 16'h4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_req = 1'b0;
    logic irq_drop_on_wr = 1'b0;
    logic dec_halt, dec_trap, dec_ien, dec_ret;
    logic [TW-1:0] dec_trap_num;
    logic [AW-1:0] mem_addr, pc_o;
    logic mem_rd, mem_wr, halted_o, ien_o, super_o, trap_err_o;
    logic [DW-1:0] mem_wdata, mem_rdata, ir_o;
    logic [DW-1:0] mem [0:2047];
    int rd_cnt, wr_cnt;
    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    assign dec_halt     = ir_o[15:12] == 4'd1;
    assign dec_trap     = ir_o[15:12] == 4'd2;
    assign dec_ien      = ir_o[15:12] == 4'd3;
    assign dec_ret      = ir_o[15:12] == 4'd4;
    assign dec_trap_num = ir_o[TW-1:0];

    instr_seq #(
        .AW(AW), .DW(DW), .TW(TW), .TRAP_CNT(NT), .TRAP_BASE(TB), .START_PC(SP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .dec_halt(dec_halt), .dec_trap(dec_trap), .dec_trap_num(dec_trap_num),
        .dec_ien(dec_ien), .dec_ret(dec_ret),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc_o(pc_o), .ir_o(ir_o), .halted_o(halted_o), .ien_o(ien_o),
        .super_o(super_o), .trap_err_o(trap_err_o)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else begin
            if (mem_rd) rd_cnt <= rd_cnt + 1;
            if (mem_wr) wr_cnt <= wr_cnt + 1;
        end
    end

    always @(negedge clk) if (irq_drop_on_wr && wr_cnt > 0) irq_req = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill();
        for (int i = 0; i < 2048; i++) mem[i] = OP_HALT;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_to_halt(output int cyc);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted_o && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        nchk++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int cyc;
        // R1: reset values
        fill();
        hold_reset();
        chk("R1 pc", int'(pc_o), SP);
        chk("R1 halted", int'(halted_o), 0);
        chk("R1 ien", int'(ien_o), 0);
        chk("R1 super", int'(super_o), 0);
        chk("R1 err", int'(trap_err_o), 0);

        // R2 R3 R10: k no-ops then halt
        for (int k = 0; k < 6; k++) begin
            fill();
            for (int j = 0; j < k; j++) mem[SP + j] = OP_NOP;
            hold_reset();
            run_to_halt(cyc);
            chk("R2 pc after nops", int'(pc_o), SP + k + 1);
            chk("R2 ir holds halt", int'(ir_o), int'(OP_HALT));
            chk("R2 read count", rd_cnt, k + 1);
            chk("R10 cycles nop/halt", cyc, 4 * k + 3);
            repeat (5) @(negedge clk);
            chk("R3 halted stays", int'(halted_o), 1);
            chk("R3 no reads after halt", rd_cnt, k + 1);
        end

        // R4: request held with enable 0 is ignored
        for (int k = 1; k < 4; k++) begin
            fill();
            for (int j = 0; j < k; j++) mem[SP + j] = OP_NOP;
            mem[1] = 16'd200;
            hold_reset();
            irq_req = 1'b1;
            run_to_halt(cyc);
            chk("R4 no save write", wr_cnt, 0);
            chk("R4 pc unaffected", int'(pc_o), SP + k + 1);
            irq_req = 1'b0;
        end

        // R4 R5 R9 R10: enable then immediate entry
        for (int k = 0; k < 4; k++) begin
            fill();
            for (int j = 0; j < k; j++) mem[SP + j] = OP_NOP;
            mem[SP + k]     = OP_IEN;
            mem[SP + k + 1] = OP_NOP;
            mem[1]   = 16'd200;
            mem[200] = OP_HALT;
            hold_reset();
            irq_req = 1'b1;
            run_to_halt(cyc);
            chk("R5 saved pc in word0", int'(mem[0]), SP + k + 1);
            chk("R5 pc from vector", int'(pc_o), 201);
            chk("R5 ien cleared", int'(ien_o), 0);
            chk("R5 one write", wr_cnt, 1);
            chk("R5 mode unchanged", int'(super_o), 0);
            chk("R10 cycles irq entry", cyc, 4 * k + 10);
            irq_req = 1'b0;
        end

        // R9: enable without a request
        fill();
        mem[SP] = OP_IEN;
        hold_reset();
        run_to_halt(cyc);
        chk("R9 ien set", int'(ien_o), 1);
        chk("R9 pc advanced", int'(pc_o), SP + 2);

        // R8 R10: entry then return with request dropped at the save
        for (int k = 0; k < 3; k++) begin
            fill();
            for (int j = 0; j < k; j++) mem[SP + j] = OP_NOP;
            mem[SP + k] = OP_IEN;
            mem[1]   = 16'd200;
            mem[200] = OP_RET;
            hold_reset();
            irq_req = 1'b1;
            irq_drop_on_wr = 1'b1;
            run_to_halt(cyc);
            chk("R8 pc restored then halt", int'(pc_o), SP + k + 2);
            chk("R8 ien restored", int'(ien_o), 1);
            chk("R8 user mode", int'(super_o), 0);
            chk("R8 single entry", wr_cnt, 1);
            chk("R10 cycles return", cyc, 4 * k + 15);
            irq_drop_on_wr = 1'b0;
            irq_req = 1'b0;
        end

        // R6 R10: every valid trap number
        for (int n = 1; n <= NT; n++) begin
            fill();
            mem[SP] = OP_TRAP | DW'(n);
            mem[TB + n] = DW'(300 + 10 * n);
            hold_reset();
            run_to_halt(cyc);
            chk("R6 pc from table", int'(pc_o), 301 + 10 * n);
            chk("R6 supervisor", int'(super_o), 1);
            chk("R6 no error", int'(trap_err_o), 0);
            chk("R10 cycles trap", cyc, 8);
        end

        // R6 R8: trap handler returns to user mode
        fill();
        mem[SP] = OP_TRAP | 16'd2;
        mem[TB + 2] = 16'd400;
        mem[400] = OP_RET;
        mem[0] = 16'd50;
        hold_reset();
        run_to_halt(cyc);
        chk("R8 return after trap pc", int'(pc_o), 51);
        chk("R8 return after trap user", int'(super_o), 0);

        // R7: invalid trap numbers 0 and NT+1..7
        for (int n = 0; n < 8; n++) begin
            if (n >= 1 && n <= NT) continue;
            fill();
            mem[SP] = OP_TRAP | DW'(n);
            hold_reset();
            rst_n = 1'b1;
            repeat (30) @(negedge clk);
            chk("R7 error set", int'(trap_err_o), 1);
            chk("R7 pc unchanged", int'(pc_o), SP);
            chk("R7 mode unchanged", int'(super_o), 0);
            chk("R7 not halted", int'(halted_o), 0);
            chk("R7 no writes", wr_cnt, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule